// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag comparators use, and gives the user two ways to change them and one way to read them back. The programming method is fixed while master reset is held. In parallel mode, each write-clock edge that sees the load strobe together with the write enable takes one bus word into the next slice of the offset pair. In serial mode, each write-clock edge that sees the serial enable takes one bit. Readback runs on the read clock, one bus word per strobed edge, in either mode.

Both loading and readback walk the same fixed slice order: the almost-empty offset from its low slice upward, then the almost-full offset the same way, then back to the start. The number of slices per offset is the offset width divided by the bus width, rounded up, so a narrow bus takes more cycles per pass than a wide one. Master reset fills both offsets with one of eight defaults. Partial reset only restarts the sequence pointers.

Top module: `ofs_reg_loader`

## Requirements
- R1: While master reset (`mrst_n` low) is applied, both offsets take the default value 2^(`cfg_dflt`+3)-1, truncated to AW bits, the slice pointers return to slice 0, and `rd_data` is zero.
- R2: The programming mode is taken from `cfg_serial` during master reset (1 = serial, 0 = parallel). Changing `cfg_serial` afterward has no effect until the next master reset.
- R3: In parallel mode, each write-clock edge with `load` and `wr_en` high stores `wr_data` into slice k of the write pointer and then advances the pointer. With NS = ceil(AW/DW) slices per offset, slices 0..NS-1 are the almost-empty offset, lowest bits first. Slices NS..2NS-1 are the almost-full offset in the same order. After slice 2NS-1 the pointer wraps to slice 0.
- R4: Bus bits that fall at or above bit AW of an offset are discarded on load.
- R5: In serial mode, each write-clock edge with `ser_en` high stores `ser_bit` as bit j and then advances j. Bit j is almost-empty bit j for j < AW, and almost-full bit j-AW otherwise. j wraps from 2AW-1 to 0.
- R6: In serial mode the parallel strobe changes nothing. In parallel mode `ser_en` changes nothing.
- R7: A read-clock edge with `load` and `rd_en` high places slice k of the read pointer on `rd_data` and advances the pointer with the same order and wrap as R3. Bits above the offset width read as zero. This works in both modes.
- R8: Partial reset (`prst_n` low at a clock edge) returns the write, serial and read pointers to the start. It keeps both offset values, and takes priority over any load in that cycle.
- R9: `ae_ofs` and `af_ofs` show a newly loaded value right after the write-clock edge that stored it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous in each domain, active low |
| cfg_serial | input | 1 | Programming mode, sampled during master reset |
| cfg_dflt | input | 3 | Default offset selector, sampled during master reset |
| load | input | 1 | Offset access strobe |
| wr_en | input | 1 | Write enable, qualifies a parallel load |
| wr_data | input | DW | Parallel load word |
| ser_en | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial data bit |
| rd_en | input | 1 | Read enable, qualifies a readback |
| rd_data | output | DW | Readback word, registered |
| ae_ofs | output | AW | Almost-empty offset to the flag logic |
| af_ofs | output | AW | Almost-full offset to the flag logic |

## Verification
A load is visible on `ae_ofs`/`af_ofs` one write-clock edge after it is presented. The bench drives each load at a falling edge and compares the offsets at the next falling edge, which also covers R9. A readback word is due on `rd_data` at the read-clock edge that accepts the strobe. The driver queues the expected slice when it raises the strobe. The monitor waits for an accepting rising edge, samples 2 ns after it, and pops the queue, so every comparison lands exactly one register stage after its request.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   // default offset chosen by a 3-bit selector: 2^(sel+3)-1
   function automatic logic [31:0] dflt_ofs(input logic [2:0] sel);
      return (32'd1 << (int'(sel) + 3)) - 32'd1;
   endfunction
endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
   import ofs_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 9,
   localparam int NS  = (AW + DW - 1) / DW,
   localparam int PW  = NS * DW,
   localparam int SW  = 2 * PW
) (
   input  logic          wr_clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          cfg_serial,
   input  logic [2:0]    cfg_dflt,
   input  logic          load,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          ser_en,
   input  logic          ser_bit,
   output logic [SW-1:0] store,
   output logic          ser_mode
);
   localparam int NW  = 2 * NS;
   localparam int WPW = $clog2(NW);
   localparam int SPW = $clog2(2 * AW);
   localparam int SIW = $clog2(SW);

   logic [WPW-1:0] wptr;
   logic [SPW-1:0] sptr;
   logic [SIW-1:0] bitpos;
   logic [SW-1:0]  vmask;
   logic [SW-1:0]  dflt_vec;
   logic [AW-1:0]  dval;

   // bits of each padded offset that really hold offset bits
   for (genvar b = 0; b < SW; b++) begin : g_mask
      assign vmask[b] = ((b % PW) < AW);
   end

   always_comb begin
      dval     = AW'(dflt_ofs(cfg_dflt));
      dflt_vec = '0;
      dflt_vec[AW-1:0]  = dval;
      dflt_vec[PW +: AW] = dval;
   end

   // serial bit index to position in the padded pair
   always_comb begin
      if (sptr < SPW'(AW)) bitpos = SIW'(sptr);
      else                 bitpos = SIW'(PW) + SIW'(sptr) - SIW'(AW);
   end

   always_ff @(posedge wr_clk or negedge mrst_n) begin
      if (!mrst_n) begin
         ser_mode <= cfg_serial;
         store    <= dflt_vec;
         wptr     <= '0;
         sptr     <= '0;
      end else if (!prst_n) begin
         wptr <= '0;
         sptr <= '0;
      end else if (ser_mode) begin
         if (ser_en) begin
            store[bitpos] <= ser_bit;
            sptr <= (sptr == SPW'(2 * AW - 1)) ? '0 : sptr + 1'b1;
         end
      end else if (load && wr_en) begin
         store[int'(wptr) * DW +: DW] <= wr_data & vmask[int'(wptr) * DW +: DW];
         wptr <= (wptr == WPW'(NW - 1)) ? '0 : wptr + 1'b1;
      end
   end
endmodule

// File: rtl/ofs_rd_seq.sv
module ofs_rd_seq #(
   parameter int AW = 12,
   parameter int DW = 9,
   localparam int NS = (AW + DW - 1) / DW,
   localparam int SW = 2 * NS * DW
) (
   input  logic          rd_clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          load,
   input  logic          rd_en,
   input  logic [SW-1:0] store,
   output logic [DW-1:0] rd_data
);
   localparam int NW  = 2 * NS;
   localparam int RPW = $clog2(NW);

   logic [RPW-1:0] rptr;

   always_ff @(posedge rd_clk or negedge mrst_n) begin
      if (!mrst_n) begin
         rptr    <= '0;
         rd_data <= '0;
      end else if (!prst_n) begin
         rptr <= '0;
      end else if (load && rd_en) begin
         rd_data <= store[int'(rptr) * DW +: DW];
         rptr    <= (rptr == RPW'(NW - 1)) ? '0 : rptr + 1'b1;
      end
   end
endmodule

// File: rtl/ofs_reg_loader.sv
module ofs_reg_loader #(
   parameter int AW = 12,
   parameter int DW = 9
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          cfg_serial,
   input  logic [2:0]    cfg_dflt,
   input  logic          load,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          ser_en,
   input  logic          ser_bit,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] ae_ofs,
   output logic [AW-1:0] af_ofs
);
   localparam int NS = (AW + DW - 1) / DW;
   localparam int PW = NS * DW;
   localparam int SW = 2 * PW;

   if (AW < 2 || AW > 30) begin : g_bad_aw
      $error("ofs_reg_loader: AW must lie in 2..30");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ofs_reg_loader: DW must be at least 1");
   end

   logic [SW-1:0] store;
   logic          ser_mode;

   ofs_wr_seq #(.AW(AW), .DW(DW)) u_wr (
      .wr_clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .cfg_serial(cfg_serial), .cfg_dflt(cfg_dflt),
      .load(load), .wr_en(wr_en), .wr_data(wr_data),
      .ser_en(ser_en), .ser_bit(ser_bit),
      .store(store), .ser_mode(ser_mode)
   );

   ofs_rd_seq #(.AW(AW), .DW(DW)) u_rd (
      .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .load(load), .rd_en(rd_en), .store(store), .rd_data(rd_data)
   );

   assign ae_ofs = store[AW-1:0];
   assign af_ofs = store[PW +: AW];
endmodule

// File: rtl/ofs_reg_loader_chk.sv
module ofs_reg_loader_chk #(
   parameter int AW = 12,
   parameter int DW = 9
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          mrst_n,
   input logic          prst_n,
   input logic          load,
   input logic          wr_en,
   input logic          rd_en,
   input logic          ser_en,
   input logic          ser_mode,
   input logic [DW-1:0] rd_data,
   input logic [AW-1:0] ae_ofs,
   input logic [AW-1:0] af_ofs
);
   // R2: mode held between master resets
   a_r2_mode_fixed: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      mrst_n |=> $stable(ser_mode));

   // R6: parallel strobe has no effect in serial mode
   a_r6_par_ignored: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      (ser_mode && !ser_en) |=> $stable({af_ofs, ae_ofs}));

   // R6: serial enable has no effect in parallel mode
   a_r6_ser_ignored: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      (!ser_mode && !(load && wr_en)) |=> $stable({af_ofs, ae_ofs}));

   // R5: a serial edge changes at most one offset bit
   a_r5_one_bit: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      (ser_mode && ser_en) |=> ($countones({af_ofs, ae_ofs} ^ $past({af_ofs, ae_ofs})) <= 1));

   // R8: partial reset keeps both offsets
   a_r8_prst_keeps: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      !prst_n |=> $stable({af_ofs, ae_ofs}));

   // R7: readback word only moves on a strobed read edge
   a_r7_rd_hold: assert property (@(posedge rd_clk) disable iff (!mrst_n)
      !(load && rd_en && prst_n) |=> $stable(rd_data));
endmodule

bind ofs_reg_loader ofs_reg_loader_chk #(.AW(AW), .DW(DW)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
   .load(load), .wr_en(wr_en), .rd_en(rd_en), .ser_en(ser_en),
   .ser_mode(ser_mode), .rd_data(rd_data), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/ofs_reg_loader_tb.sv
module ofs_reg_loader_tb;
   localparam int AW = 12;
   localparam int DW = 9;

   typedef struct {
      string          tag;
      logic [DW-1:0]  val;
   } rd_item_t;

   logic          clk = 1'b0;
   logic          mrst_n = 1'b0;
   logic          prst_n = 1'b1;
   logic          cfg_serial = 1'b0;
   logic [2:0]    cfg_dflt = 3'd2;
   logic          load = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          ser_en = 1'b0;
   logic          ser_bit = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] ae_ofs;
   logic [AW-1:0] af_ofs;

   int n_vec = 0;
   int n_bad = 0;
   rd_item_t exp_q[$];

   always #5 clk = ~clk;

   ofs_reg_loader #(.AW(AW), .DW(DW)) u_dut (
      .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .cfg_serial(cfg_serial), .cfg_dflt(cfg_dflt),
      .load(load), .wr_en(wr_en), .wr_data(wr_data),
      .ser_en(ser_en), .ser_bit(ser_bit), .rd_en(rd_en),
      .rd_data(rd_data), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_ofs(input string tag, input logic [AW-1:0] ae, input logic [AW-1:0] af);
      chk({tag, " ae"}, 32'(ae_ofs), 32'(ae));
      chk({tag, " af"}, 32'(af_ofs), 32'(af));
   endtask

   task automatic master_reset(input logic ser, input logic [2:0] sel);
      @(negedge clk);
      cfg_serial = ser;
      cfg_dflt   = sel;
      mrst_n     = 1'b0;
      repeat (2) @(negedge clk);
      mrst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic part_reset();
      @(negedge clk);
      prst_n = 1'b0;
      @(negedge clk);
      prst_n = 1'b1;
   endtask

   task automatic pwrite(input logic [DW-1:0] d);
      @(negedge clk);
      load = 1'b1; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      load = 1'b0; wr_en = 1'b0;
   endtask

   task automatic sshift(input logic b);
      @(negedge clk);
      ser_en = 1'b1; ser_bit = b;
      @(negedge clk);
      ser_en = 1'b0;
   endtask

   task automatic rd_word(input string tag, input logic [DW-1:0] exp);
      rd_item_t it;
      @(negedge clk);
      it.tag = tag;
      it.val = exp;
      exp_q.push_back(it);
      load = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      load = 1'b0; rd_en = 1'b0;
   endtask

   // monitor: result due at the accepting read edge
   initial begin
      forever begin
         @(posedge clk);
         if (load && rd_en && mrst_n && prst_n && exp_q.size() > 0) begin
            rd_item_t it;
            #2;
            it = exp_q.pop_front();
            chk(it.tag, 32'(rd_data), 32'(it.val));
         end
      end
   end

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] sae;
      logic [AW-1:0] saf;
      repeat (3) @(negedge clk);
      // R1 reset state, parallel mode, default sel 2 -> 31
      chk_ofs("R1 dflt during reset", 12'd31, 12'd31);
      chk("R1 rd_data reset", 32'(rd_data), 32'd0);
      mrst_n = 1'b1;
      @(negedge clk);
      cfg_serial = 1'b1;               // R2: must be ignored now

      // R3/R4 parallel load order, upper bus bits dropped
      pwrite(9'h1A5);
      chk_ofs("R9 ae low slice visible next edge", 12'h1A5, 12'd31);
      pwrite(9'h1FF);
      pwrite(9'h033);
      pwrite(9'h005);
      chk_ofs("R2 R3 R4 parallel load", 12'hFA5, 12'hA33);

      // R6 serial ignored in parallel mode
      sshift(1'b0); sshift(1'b0); sshift(1'b1);
      chk_ofs("R6 serial ignored", 12'hFA5, 12'hA33);

      // R7 readback order, zero padding, wrap
      rd_word("R7 slice0", 9'h1A5);
      rd_word("R7 slice1 padded", 9'h007);
      rd_word("R7 slice2", 9'h033);
      rd_word("R7 slice3 padded", 9'h005);
      rd_word("R7 wrap", 9'h1A5);

      // R8 partial reset restarts read pointer, keeps values
      part_reset();
      chk_ofs("R8 values kept", 12'hFA5, 12'hA33);
      rd_word("R8 read restarts", 9'h1A5);

      // R3 write wrap then R8 write pointer restart
      pwrite(9'h0F0);
      chk_ofs("R3 R9 write wrap", 12'hEF0, 12'hA33);
      part_reset();
      pwrite(9'h011);
      chk_ofs("R8 write restarts", 12'hE11, 12'hA33);

      // serial mode, default sel 0 -> 7
      master_reset(1'b1, 3'd0);
      chk_ofs("R1 serial dflt", 12'd7, 12'd7);
      chk("R1 rd_data cleared", 32'(rd_data), 32'd0);
      cfg_serial = 1'b0;               // R2
      pwrite(9'h1FF);
      chk_ofs("R6 parallel ignored", 12'd7, 12'd7);

      sae = 12'h5A3;
      saf = 12'h3C6;
      for (int j = 0; j < 2 * AW; j++) begin
         sshift(j < AW ? sae[j] : saf[j - AW]);
      end
      chk_ofs("R2 R5 serial load", 12'h5A3, 12'h3C6);

      rd_word("R7 serial slice0", 9'h1A3);
      rd_word("R7 serial slice1", 9'h002);
      rd_word("R7 serial slice2", 9'h1C6);
      rd_word("R7 serial slice3", 9'h001);

      sshift(1'b0);
      chk_ofs("R5 serial wrap", 12'h5A2, 12'h3C6);

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) chk("R7 pending reads", 32'(exp_q.size()), 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule